// File: doc/BRIEF.md
# GPIO Edge-Event Interrupt Unit

This block watches 54 general-purpose input pins and records transitions on them. Each pin has its own rising-edge enable and falling-edge enable. When an enabled transition is seen on a pin that is configured as an input, a sticky event bit for that pin is set. The event bits are combined into three level-sensitive interrupt lines, each covering a fixed and uneven range of pins. Software reads the event words to find the source and then clears bits by writing ones to them.

The pins are asynchronous to the block clock. They pass through a two-flop synchronizer, and an edge is found by comparing the synchronized value with its value one clock earlier. An enabled pin transition therefore reaches its event bit and interrupt line three clock edges after the pin changes. Every per-pin register is held as a pair of 32-bit words on a small word-addressed bus. The upper word of each pair uses only its low 22 bits.

Top module: `gpio_edge_irq_top`

## Requirements
- R1: After reset, every register word reads as zero, all pins are inputs, and all three interrupt lines are low. This also holds when reset is applied while events are pending.
- R2: The register map uses word addresses 0/1 for pin direction (1 = output), 2/3 for rising enable, 4/5 for falling enable, and 6/7 for event status. Even addresses hold pins 0-31 in bits 0-31. Odd addresses hold pins 32-53 in bits 0-21. Configuration words read back what was written. Bits 31:22 of every odd-address word read as zero and ignore writes.
- R3: A 0-to-1 transition on an input pin with rising enable set sets that pin's event bit three clock edges after the pin changes.
- R4: A 1-to-0 transition on an input pin with falling enable set sets that pin's event bit three clock edges after the pin changes.
- R5: A transition whose edge type is not enabled sets no event bit. With both enables set, either transition sets the bit.
- R6: A pin whose direction bit is 1 (output) never sets its event bit, whatever its enables and transitions.
- R7: Interrupt line 0 is high while any event bit of pins 0-27 is set. Line 1 does the same for pins 28-45, and line 2 for pins 46-53.
- R8: Writing an event word clears each bit written as 1 and keeps each bit written as 0. An interrupt line falls once its group has no set bits left.
- R9: If a new enabled edge on a pin lands in the same cycle as a write-one-to-clear of that pin's bit, the bit stays set.
- R10: An event bit and its interrupt line stay set until software clears the bit, even after the pin returns to its earlier level.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | 3 | Register word address |
| bus_wr_en | input | 1 | Write strobe, one word per cycle |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for bus_addr, combinational |
| pin_in | input | 54 | Asynchronous pin levels |
| irq_o | output | 3 | Level interrupt lines for the three pin groups |

## Verification
Every pin in turn is driven through a rise and a fall under rising-only and then falling-only enables. This separates the correct edge polarity from its opposite, and each pin's word and bit position from its neighbours. It also checks that the pin lands on the right interrupt line, so group boundary errors show up at pins 27/28, 31/32 and 45/46. All-pins patterns with both enables, with direction set to output, and with partial clear masks show masking and clearing group by group. A clear write timed into the same cycle as a new edge separates edge-wins from clear-wins priority.

// File: rtl/gpio_evt_pkg.sv
package gpio_evt_pkg;

    localparam int unsigned WORD_W = 32;
    localparam int unsigned ADDR_W = 3;
    localparam int unsigned IRQ_N  = 3;

    // Register word selector; bit 0 picks the upper word of a pair,
    // bits 2:1 pick the register kind.
    typedef enum logic [ADDR_W-1:0] {
        SEL_DIR_LO  = 3'd0,
        SEL_DIR_HI  = 3'd1,
        SEL_RISE_LO = 3'd2,
        SEL_RISE_HI = 3'd3,
        SEL_FALL_LO = 3'd4,
        SEL_FALL_HI = 3'd5,
        SEL_EVT_LO  = 3'd6,
        SEL_EVT_HI  = 3'd7
    } reg_sel_e;

    localparam logic [1:0] KIND_EVT = 2'd3;

endpackage

// File: rtl/gpio_pin_sync.sv
module gpio_pin_sync #(
    parameter int unsigned NUM_PINS = 54,
    parameter int unsigned STAGES   = 2
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [NUM_PINS-1:0] pin_async,
    output logic [NUM_PINS-1:0] sync_o,
    output logic [NUM_PINS-1:0] prev_o
);

    logic [STAGES-1:0][NUM_PINS-1:0] chain_q;
    logic [NUM_PINS-1:0]             prev_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            chain_q[0] <= '0;
        end else begin
            chain_q[0] <= pin_async;
        end
    end

    generate
        for (genvar s = 1; s < STAGES; s++) begin : g_stage
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) begin
                    chain_q[s] <= '0;
                end else begin
                    chain_q[s] <= chain_q[s-1];
                end
            end
        end
    endgenerate

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            prev_q <= '0;
        end else begin
            prev_q <= chain_q[STAGES-1];
        end
    end

    assign sync_o = chain_q[STAGES-1];
    assign prev_o = prev_q;

endmodule

// File: rtl/gpio_edge_detect.sv
module gpio_edge_detect #(
    parameter int unsigned NUM_PINS = 54
) (
    input  logic [NUM_PINS-1:0] sync_i,
    input  logic [NUM_PINS-1:0] prev_i,
    input  logic [NUM_PINS-1:0] rise_en,
    input  logic [NUM_PINS-1:0] fall_en,
    input  logic [NUM_PINS-1:0] is_output,
    output logic [NUM_PINS-1:0] evt_o
);

    generate
        for (genvar p = 0; p < NUM_PINS; p++) begin : g_pin
            logic went_up;
            logic went_down;
            assign went_up   =  sync_i[p] & ~prev_i[p];
            assign went_down = ~sync_i[p] &  prev_i[p];
            assign evt_o[p]  = ~is_output[p] &
                               ((went_up & rise_en[p]) | (went_down & fall_en[p]));
        end
    endgenerate

endmodule

// File: rtl/gpio_evt_regs.sv
module gpio_evt_regs
    import gpio_evt_pkg::*;
#(
    parameter int unsigned NUM_PINS = 54
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [ADDR_W-1:0]   bus_addr,
    input  logic                bus_wr_en,
    input  logic [WORD_W-1:0]   bus_wdata,
    input  logic [NUM_PINS-1:0] evt_set,
    output logic [NUM_PINS-1:0] dir_q,
    output logic [NUM_PINS-1:0] rise_q,
    output logic [NUM_PINS-1:0] fall_q,
    output logic [NUM_PINS-1:0] status_q,
    output logic [WORD_W-1:0]   bus_rdata
);

    localparam int unsigned HI_W  = NUM_PINS - WORD_W;
    localparam int unsigned PAD_W = 2 * WORD_W - NUM_PINS;
    localparam int unsigned CFG_N = 3;

    reg_sel_e            sel;
    logic                hi_word;
    logic [1:0]          kind;
    logic [NUM_PINS-1:0] wr_vec;
    logic [NUM_PINS-1:0] lane_msk;
    logic [NUM_PINS-1:0] clr_vec;

    logic [CFG_N-1:0][NUM_PINS-1:0] cfg_q;

    assign sel     = reg_sel_e'(bus_addr);
    assign hi_word = bus_addr[0];
    assign kind    = bus_addr[ADDR_W-1:1];

    // Spread the bus word onto the pin vector; upper-word bits past the
    // last pin are dropped here, so they can never be stored.
    always_comb begin
        if (hi_word) begin
            wr_vec   = {bus_wdata[HI_W-1:0], {WORD_W{1'b0}}};
            lane_msk = {{HI_W{1'b1}}, {WORD_W{1'b0}}};
        end else begin
            wr_vec   = {{HI_W{1'b0}}, bus_wdata};
            lane_msk = {{HI_W{1'b0}}, {WORD_W{1'b1}}};
        end
    end

    generate
        for (genvar c = 0; c < CFG_N; c++) begin : g_cfg
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) begin
                    cfg_q[c] <= '0;
                end else if (bus_wr_en && (kind == 2'(c))) begin
                    cfg_q[c] <= (cfg_q[c] & ~lane_msk) | wr_vec;
                end
            end
        end
    endgenerate

    assign dir_q  = cfg_q[0];
    assign rise_q = cfg_q[1];
    assign fall_q = cfg_q[2];

    assign clr_vec = (bus_wr_en && (kind == KIND_EVT)) ? wr_vec : '0;

    // Set has priority over clear in the same cycle.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            status_q <= '0;
        end else begin
            status_q <= (status_q & ~clr_vec) | evt_set;
        end
    end

    function automatic logic [WORD_W-1:0] lo_word(input logic [NUM_PINS-1:0] v);
        return v[WORD_W-1:0];
    endfunction

    function automatic logic [WORD_W-1:0] hi_part(input logic [NUM_PINS-1:0] v);
        return {{PAD_W{1'b0}}, v[NUM_PINS-1:WORD_W]};
    endfunction

    always_comb begin
        unique case (sel)
            SEL_DIR_LO:  bus_rdata = lo_word(dir_q);
            SEL_DIR_HI:  bus_rdata = hi_part(dir_q);
            SEL_RISE_LO: bus_rdata = lo_word(rise_q);
            SEL_RISE_HI: bus_rdata = hi_part(rise_q);
            SEL_FALL_LO: bus_rdata = lo_word(fall_q);
            SEL_FALL_HI: bus_rdata = hi_part(fall_q);
            SEL_EVT_LO:  bus_rdata = lo_word(status_q);
            SEL_EVT_HI:  bus_rdata = hi_part(status_q);
            default:     bus_rdata = '0;
        endcase
    end

endmodule

// File: rtl/gpio_irq_merge.sv
module gpio_irq_merge
    import gpio_evt_pkg::*;
#(
    parameter int NUM_PINS  = 54,
    parameter int GRP0_LAST = 27,
    parameter int GRP1_LAST = 45
) (
    input  logic [NUM_PINS-1:0] status_i,
    output logic [IRQ_N-1:0]    irq_o
);

    function automatic logic [NUM_PINS-1:0] span(input int lo, input int hi);
        logic [NUM_PINS-1:0] m;
        for (int i = 0; i < NUM_PINS; i++) begin
            m[i] = (i >= lo) && (i <= hi);
        end
        return m;
    endfunction

    generate
        for (genvar g = 0; g < IRQ_N; g++) begin : g_line
            localparam int LO = (g == 0) ? 0 : (g == 1) ? GRP0_LAST + 1 : GRP1_LAST + 1;
            localparam int HI = (g == 0) ? GRP0_LAST : (g == 1) ? GRP1_LAST : NUM_PINS - 1;
            localparam logic [NUM_PINS-1:0] MSK = span(LO, HI);
            assign irq_o[g] = |(status_i & MSK);
        end
    endgenerate

endmodule

// File: rtl/gpio_edge_irq_top.sv
module gpio_edge_irq_top
    import gpio_evt_pkg::*;
#(
    parameter int unsigned NUM_PINS    = 54,
    parameter int unsigned SYNC_STAGES = 2,
    parameter int          GRP0_LAST   = 27,
    parameter int          GRP1_LAST   = 45
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [2:0]          bus_addr,
    input  logic                bus_wr_en,
    input  logic [31:0]         bus_wdata,
    output logic [31:0]         bus_rdata,
    input  logic [NUM_PINS-1:0] pin_in,
    output logic [2:0]          irq_o
);

    logic [NUM_PINS-1:0] sync_q;
    logic [NUM_PINS-1:0] prev_q;
    logic [NUM_PINS-1:0] dir_q;
    logic [NUM_PINS-1:0] rise_q;
    logic [NUM_PINS-1:0] fall_q;
    logic [NUM_PINS-1:0] status_q;
    logic [NUM_PINS-1:0] evt_set;

    gpio_pin_sync #(
        .NUM_PINS (NUM_PINS),
        .STAGES   (SYNC_STAGES)
    ) sync_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .pin_async (pin_in),
        .sync_o    (sync_q),
        .prev_o    (prev_q)
    );

    gpio_edge_detect #(
        .NUM_PINS (NUM_PINS)
    ) edge_i (
        .sync_i    (sync_q),
        .prev_i    (prev_q),
        .rise_en   (rise_q),
        .fall_en   (fall_q),
        .is_output (dir_q),
        .evt_o     (evt_set)
    );

    gpio_evt_regs #(
        .NUM_PINS (NUM_PINS)
    ) regs_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .bus_addr  (bus_addr),
        .bus_wr_en (bus_wr_en),
        .bus_wdata (bus_wdata),
        .evt_set   (evt_set),
        .dir_q     (dir_q),
        .rise_q    (rise_q),
        .fall_q    (fall_q),
        .status_q  (status_q),
        .bus_rdata (bus_rdata)
    );

    gpio_irq_merge #(
        .NUM_PINS  (NUM_PINS),
        .GRP0_LAST (GRP0_LAST),
        .GRP1_LAST (GRP1_LAST)
    ) merge_i (
        .status_i (status_q),
        .irq_o    (irq_o)
    );

endmodule

// File: rtl/gpio_edge_irq_chk.sv
module gpio_edge_irq_chk #(
    parameter int unsigned NUM_PINS = 54
) (
    input logic                clk,
    input logic                rst_n,
    input logic [2:0]          bus_addr,
    input logic                bus_wr_en,
    input logic [31:0]         bus_rdata,
    input logic [2:0]          irq_o,
    input logic [NUM_PINS-1:0] status_q,
    input logic [NUM_PINS-1:0] dir_q,
    input logic [NUM_PINS-1:0] rise_q,
    input logic [NUM_PINS-1:0] sync_q,
    input logic [NUM_PINS-1:0] prev_q
);

    localparam int unsigned HI_W = NUM_PINS - 32;

    // R2: upper words never expose bits beyond the last pin.
    assert_hi_word_pad_R2: assert property (@(posedge clk) disable iff (!rst_n)
        bus_addr[0] |-> (bus_rdata[31:HI_W] == '0));

    // R3: an enabled rising edge on an input is captured on the next edge.
    assert_rise_captured_R3: assert property (@(posedge clk) disable iff (!rst_n)
        ((sync_q & ~prev_q & rise_q & ~dir_q) != '0) |=>
        ((status_q & $past(sync_q & ~prev_q & rise_q & ~dir_q))
            == $past(sync_q & ~prev_q & rise_q & ~dir_q)));

    // R6: output pins never gain an event bit.
    assert_output_silent_R6: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> ((status_q & ~$past(status_q) & $past(dir_q)) == '0));

    // R10: event bits only drop after a write to an event word.
    assert_status_sticky_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (($past(status_q) & ~status_q) != '0) |->
        ($past(bus_wr_en) && ($past(bus_addr[2:1]) == 2'd3)));

    // R8: an interrupt line falls only after a bus write.
    assert_irq_drop_on_write_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (($past(irq_o) & ~irq_o) != 3'b000) |-> $past(bus_wr_en));

endmodule

bind gpio_edge_irq_top gpio_edge_irq_chk #(.NUM_PINS(NUM_PINS)) chk_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .bus_addr  (bus_addr),
    .bus_wr_en (bus_wr_en),
    .bus_rdata (bus_rdata),
    .irq_o     (irq_o),
    .status_q  (status_q),
    .dir_q     (dir_q),
    .rise_q    (rise_q),
    .sync_q    (sync_q),
    .prev_q    (prev_q)
);

// File: tb/gpio_edge_irq_top_tb_top.sv
module gpio_edge_irq_top_tb_top;

    localparam int N = 54;

    logic        clk = 1'b0;
    logic        rst_n;
    logic [2:0]  bus_addr;
    logic        bus_wr_en;
    logic [31:0] bus_wdata;
    logic [31:0] bus_rdata;
    logic [N-1:0] pins;
    logic [2:0]  irq;

    int n_cmp = 0;
    int n_bad = 0;
    bit done  = 1'b0;

    always #5 clk = ~clk;

    gpio_edge_irq_top dut_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .bus_addr  (bus_addr),
        .bus_wr_en (bus_wr_en),
        .bus_wdata (bus_wdata),
        .bus_rdata (bus_rdata),
        .pin_in    (pins),
        .irq_o     (irq)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [2:0] a, input logic [31:0] d);
        bus_addr  = a;
        bus_wdata = d;
        bus_wr_en = 1'b1;
        @(posedge clk);
        @(negedge clk);
        bus_wr_en = 1'b0;
    endtask

    task automatic rd(input logic [2:0] a, output logic [31:0] d);
        bus_addr = a;
        #1;
        d = bus_rdata;
    endtask

    task automatic settle();
        repeat (3) @(posedge clk);
        @(negedge clk);
    endtask

    function automatic logic [31:0] bitv(input int p);
        return 32'h1 << (p % 32);
    endfunction

    function automatic logic [2:0] grp_line(input int p);
        if (p < 28) return 3'b001;
        if (p < 46) return 3'b010;
        return 3'b100;
    endfunction

    task automatic check_evt(input string tag, input int p, input bit set);
        logic [31:0] lo;
        logic [31:0] hi;
        rd(3'd6, lo);
        rd(3'd7, hi);
        chk({tag, " lo word"}, lo, (set && p < 32)  ? bitv(p) : 32'h0);
        chk({tag, " hi word"}, hi, (set && p >= 32) ? bitv(p) : 32'h0);
        chk({tag, " R7 irq"}, {29'h0, irq}, {29'h0, set ? grp_line(p) : 3'b000});
    endtask

    task automatic enable_pin(input int p, input bit rise, input bit fall);
        wr(3'd2, (rise && p < 32)  ? bitv(p) : 32'h0);
        wr(3'd3, (rise && p >= 32) ? bitv(p) : 32'h0);
        wr(3'd4, (fall && p < 32)  ? bitv(p) : 32'h0);
        wr(3'd5, (fall && p >= 32) ? bitv(p) : 32'h0);
    endtask

    task automatic clear_pin(input int p);
        wr((p < 32) ? 3'd6 : 3'd7, bitv(p));
    endtask

    task automatic summary();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_cmp++;
            n_bad++;
            $display("FAIL watchdog expired actual=running expected=finished");
            summary();
            $finish;
        end
    end

    initial begin
        logic [31:0] v;
        rst_n     = 1'b0;
        pins      = '0;
        bus_addr  = '0;
        bus_wr_en = 1'b0;
        bus_wdata = '0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1: reset state
        for (int a = 0; a < 8; a++) begin
            rd(3'(a), v);
            chk("R1 reset word", v, 32'h0);
        end
        chk("R1 reset irq", {29'h0, irq}, 32'h0);

        // R2: read-back and upper-word padding
        for (int a = 0; a < 6; a++) begin
            wr(3'(a), 32'hA5C3_5A3C ^ (32'(a) * 32'h0101_0101));
            rd(3'(a), v);
            chk("R2 readback", v, (a % 2 == 1) ?
                ((32'hA5C3_5A3C ^ (32'(a) * 32'h0101_0101)) & 32'h003F_FFFF) :
                (32'hA5C3_5A3C ^ (32'(a) * 32'h0101_0101)));
        end
        wr(3'd3, 32'hFFFF_FFFF);
        rd(3'd3, v);
        chk("R2 hi pad", v, 32'h003F_FFFF);
        for (int a = 0; a < 6; a++) wr(3'(a), 32'h0);
        settle();

        // R3 R4 R5 R7 R8: sweep every pin
        for (int p = 0; p < N; p++) begin
            enable_pin(p, 1'b1, 1'b0);
            pins[p] = 1'b1;
            settle();
            check_evt("R3 rise", p, 1'b1);
            clear_pin(p);
            check_evt("R8 clear", p, 1'b0);
            pins[p] = 1'b0;
            settle();
            check_evt("R5 fall ignored", p, 1'b0);
            enable_pin(p, 1'b0, 1'b1);
            pins[p] = 1'b1;
            settle();
            check_evt("R5 rise ignored", p, 1'b0);
            pins[p] = 1'b0;
            settle();
            check_evt("R4 fall", p, 1'b1);
            clear_pin(p);
        end

        // R6: outputs produce nothing
        wr(3'd0, 32'hFFFF_FFFF);
        wr(3'd1, 32'h003F_FFFF);
        for (int a = 2; a < 6; a++) wr(3'(a), 32'hFFFF_FFFF);
        pins = '1;
        settle();
        rd(3'd6, v); chk("R6 lo after rise", v, 32'h0);
        rd(3'd7, v); chk("R6 hi after rise", v, 32'h0);
        pins = '0;
        settle();
        rd(3'd6, v); chk("R6 lo after fall", v, 32'h0);
        rd(3'd7, v); chk("R6 hi after fall", v, 32'h0);
        chk("R6 irq", {29'h0, irq}, 32'h0);
        wr(3'd0, 32'h0);
        wr(3'd1, 32'h0);

        // R5 both edges, R8 partial clears by group
        pins = '1;
        settle();
        rd(3'd6, v); chk("R5 both lo", v, 32'hFFFF_FFFF);
        rd(3'd7, v); chk("R5 both hi", v, 32'h003F_FFFF);
        chk("R7 all lines", {29'h0, irq}, 32'h7);
        wr(3'd6, 32'h0FFF_FFFF);
        rd(3'd6, v); chk("R8 partial lo", v, 32'hF000_0000);
        chk("R8 line0 drop", {29'h0, irq}, 32'h6);
        wr(3'd7, 32'h0);
        rd(3'd7, v); chk("R8 zeros keep", v, 32'h003F_FFFF);
        wr(3'd6, 32'hFFFF_FFFF);
        chk("R8 line1 held by hi", {29'h0, irq}, 32'h6);
        wr(3'd7, 32'h0000_3FFF);
        chk("R8 line1 drop", {29'h0, irq}, 32'h4);
        wr(3'd7, 32'h003F_C000);
        chk("R8 line2 drop", {29'h0, irq}, 32'h0);
        pins = '0;
        settle();
        rd(3'd6, v); chk("R5 both fall lo", v, 32'hFFFF_FFFF);
        rd(3'd7, v); chk("R5 both fall hi", v, 32'h003F_FFFF);
        wr(3'd6, 32'hFFFF_FFFF);
        wr(3'd7, 32'hFFFF_FFFF);
        chk("R8 all clear irq", {29'h0, irq}, 32'h0);

        // R9: edge coinciding with clear wins
        enable_pin(5, 1'b1, 1'b1);
        pins[5] = 1'b1;
        settle();
        rd(3'd6, v); chk("R9 setup", v, bitv(5));
        pins[5] = 1'b0;
        @(posedge clk);
        @(posedge clk);
        @(negedge clk);
        wr(3'd6, bitv(5));
        rd(3'd6, v); chk("R9 edge wins", v, bitv(5));
        chk("R9 irq held", {29'h0, irq}, 32'h1);
        wr(3'd6, bitv(5));
        rd(3'd6, v); chk("R8 plain clear", v, 32'h0);

        // R10: stickiness across pin return
        enable_pin(40, 1'b1, 1'b0);
        pins[40] = 1'b1;
        settle();
        repeat (20) @(posedge clk);
        @(negedge clk);
        pins[40] = 1'b0;
        settle();
        rd(3'd7, v); chk("R10 sticky", v, bitv(40));
        chk("R10 irq level", {29'h0, irq}, 32'h2);

        // R1: reset while pending
        rst_n = 1'b0;
        #1;
        chk("R1 reset clears irq", {29'h0, irq}, 32'h0);
        @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        for (int a = 0; a < 8; a++) begin
            rd(3'(a), v);
            chk("R1 reset pending word", v, 32'h0);
        end

        done = 1'b1;
        summary();
        $finish;
    end

endmodule